// File: doc/BRIEF.md
# Gate Driver Fault Protection Controller

This block is the digital supervisor for one switching power stage. It gates a low-side drive enable from a PWM input and an auxiliary drive enable from a command input. It catches overcurrent and external comparator faults in latches, and reports any fault on an active-low line. All inputs are already digital and synchronous to `clk_i`.

An overcurrent flag sets a set-dominant latch that cuts the drive at once. The same event starts a non-retriggerable one-shot, which holds the fault report low for `WIN_CYC` cycles. The drive stays off for that whole window, even when the latch has already been cleared. Under a persistent overcurrent with the clear input held low and PWM held high, this gives a regular retry. The drive comes on for one cycle, the overcurrent cuts it again, and it stays off for one window.

Comparator faults set a second latch, which also pulls the report low. Any low report also sets an auxiliary latch, and that latch keeps the auxiliary drive off until it is explicitly cleared. Power-on-reset clears everything and keeps both drives off.

Top module: `gdfp_fault_ctrl`

## Requirements
- R1: While `por_i` is 1, `drv_en_o` and `aux_en_o` are 0 and `flt_n_o` is 1, whatever the other inputs are. After `por_i` falls, no latch is set and no window is running.
- R2: When `ocp_i` is 1 at a clock edge, `drv_en_o` is 0 in the cycle after it. The overcurrent latch stays set as long as `ocp_i` is 1, even if its clear condition is present in the same cycles (set wins).
- R3: The overcurrent latch clears at the first edge where `ocp_i` is 0 and either `pwm_i` is 0 or `flt_clr_n_i` is 0. While `pwm_i`, `flt_clr_n_i` and `!ocp_i` all stay 1, it holds and the drive stays off.
- R4: When the overcurrent latch goes from clear to set, `flt_n_o` is 0 for exactly `WIN_CYC` cycles, starting in the cycle after that edge.
- R5: The window cannot be retriggered. A new overcurrent set during a running window does not lengthen it. A latch that stays set after the window ends does not start a new window.
- R6: While `flt_n_o` is 0, `drv_en_o` is 0, even when the overcurrent latch is already clear.
- R7: With `flt_clr_n_i`=0 and `pwm_i`=1, an overcurrent that appears whenever the drive is on makes `drv_en_o` repeat a pattern with period `WIN_CYC`+1. The pattern is one cycle high followed by `WIN_CYC` cycles low.
- R8: A 1 on any bit of `cmp_i` at an edge sets the comparator latch. From the next cycle it holds `flt_n_o` at 0. The latch clears at an edge where `flt_clr_n_i` is 0 and no `cmp_i` bit is 1; set wins.
- R9: With no fault latched and `flt_n_o` at 1, `aux_en_o` equals `aux_cmd_i`.
- R10: A cycle with `flt_n_o` at 0 sets the auxiliary latch at the following edge. That latch forces `aux_en_o` to 0 until an edge where `aux_clr_i` is 1 and `flt_n_o` is 1; set wins.
- R11: With no fault latched and `flt_n_o` at 1, `drv_en_o` equals `pwm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on-reset, active high, synchronous clear plus output forcing |
| pwm_i | input | 1 | PWM request for the low-side drive |
| flt_clr_n_i | input | 1 | Active-low clear for the overcurrent and comparator latches |
| ocp_i | input | 1 | Overcurrent comparator flag |
| cmp_i | input | N_CMP | Comparator fault flags |
| aux_cmd_i | input | 1 | Auxiliary drive command |
| aux_clr_i | input | 1 | Active-high clear of the auxiliary latch |
| drv_en_o | output | 1 | Low-side drive enable |
| aux_en_o | output | 1 | Auxiliary drive enable |
| flt_n_o | output | 1 | Active-low fault report |

## Verification
The bench runs with a five-cycle window. During reset it sweeps all 256 input combinations, and in idle it sweeps PWM, command and comparator combinations. This separates plain pass-through from the effect of any latch. Single overcurrent pulses are used to measure the window length and to show that the latch holds after the window. A second set inside the window shows that the window is not retriggered, and a held flag under an active clear shows that set wins. A closed loop, where the overcurrent appears whenever the drive is on, tells the retry period apart from an off-by-one window. Order tests on the clear inputs, applied during and after a report, show the set-dominance of the comparator and auxiliary latches.

// File: rtl/gdfp_pkg.sv
package gdfp_pkg;
  // latch slots in the latch bank
  localparam int unsigned LAT_OC  = 0;
  localparam int unsigned LAT_CMP = 1;
  localparam int unsigned LAT_AUX = 2;
  localparam int unsigned N_LAT   = 3;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((max_val >> w) != 0) w++;
    return w;
  endfunction
endpackage

// File: rtl/gdfp_sd_latch.sv
module gdfp_sd_latch (
  input  logic clk_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic rst_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i) begin
    if (clr_i)      q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;   // set dominates reset
    else if (rst_i) q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/gdfp_oneshot.sv
module gdfp_oneshot #(
  parameter int unsigned WIN_CYC = 125
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic trig_i,
  output logic busy_o
);
  localparam int unsigned CW = gdfp_pkg::cnt_width(WIN_CYC);
  localparam logic [CW-1:0] WIN_LD = CW'(WIN_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (clr_i)              cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;  // running: ignore trig
    else if (trig_i)        cnt_q <= WIN_LD;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/gdfp_fault_ctrl.sv
module gdfp_fault_ctrl #(
  parameter int unsigned WIN_CYC = 125,
  parameter int unsigned N_CMP   = 2
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             pwm_i,
  input  logic             flt_clr_n_i,
  input  logic             ocp_i,
  input  logic [N_CMP-1:0] cmp_i,
  input  logic             aux_cmd_i,
  input  logic             aux_clr_i,
  output logic             drv_en_o,
  output logic             aux_en_o,
  output logic             flt_n_o
);
  import gdfp_pkg::*;

  logic [N_LAT-1:0] lat_set, lat_rst, lat_q;
  logic             os_busy;
  logic             fault_any;

  // set/reset terms of the latch bank
  always_comb begin
    lat_set          = '0;
    lat_rst          = '0;
    lat_set[LAT_OC]  = ocp_i;
    lat_rst[LAT_OC]  = ~pwm_i | ~flt_clr_n_i;
    lat_set[LAT_CMP] = |cmp_i;
    lat_rst[LAT_CMP] = ~flt_clr_n_i;
    lat_set[LAT_AUX] = fault_any;
    lat_rst[LAT_AUX] = aux_clr_i;
  end

  for (genvar g = 0; g < N_LAT; g++) begin : g_lat
    gdfp_sd_latch u_lat (
      .clk_i (clk_i),
      .clr_i (por_i),
      .set_i (lat_set[g]),
      .rst_i (lat_rst[g]),
      .q_o   (lat_q[g])
    );
  end

  // window starts only on a clear-to-set transition of the overcurrent latch
  gdfp_oneshot #(.WIN_CYC(WIN_CYC)) u_os (
    .clk_i  (clk_i),
    .clr_i  (por_i),
    .trig_i (ocp_i & ~lat_q[LAT_OC]),
    .busy_o (os_busy)
  );

  assign fault_any = os_busy | lat_q[LAT_CMP];

  assign flt_n_o  = por_i | ~fault_any;
  assign drv_en_o = ~por_i & pwm_i & ~lat_q[LAT_OC] & ~fault_any;
  assign aux_en_o = ~por_i & aux_cmd_i & ~lat_q[LAT_AUX] & ~fault_any;
endmodule

// File: rtl/gdfp_chk.sv
module gdfp_chk #(
  parameter int unsigned N_CMP = 2
) (
  input logic             clk_i,
  input logic             por_i,
  input logic             pwm_i,
  input logic             ocp_i,
  input logic [N_CMP-1:0] cmp_i,
  input logic             aux_cmd_i,
  input logic             drv_en_o,
  input logic             aux_en_o,
  input logic             flt_n_o
);
  // R1: outputs forced while in power-on-reset
  always @(posedge clk_i) begin
    if (por_i) begin
      p_por_outputs_r1: assert (!drv_en_o && !aux_en_o && flt_n_o)
        else $error("R1 outputs not safe during reset");
    end
  end

  // R2: overcurrent removes the drive one cycle later
  p_ocp_cuts_drive_r2: assert property (@(posedge clk_i) disable iff (por_i)
    ocp_i |=> !drv_en_o);

  // R4: an overcurrent hitting an enabled drive opens a report window
  p_ocp_report_r4: assert property (@(posedge clk_i) disable iff (por_i)
    (ocp_i && drv_en_o) |=> !flt_n_o);

  // R8: comparator fault pulls the report low
  p_cmp_report_r8: assert property (@(posedge clk_i) disable iff (por_i)
    (|cmp_i) |=> !flt_n_o);

  // R10: low report locks out the auxiliary drive in the next cycle
  p_aux_lock_r10: assert property (@(posedge clk_i) disable iff (por_i)
    !flt_n_o |=> !aux_en_o);

  // R9: auxiliary drive never on without its command
  p_aux_cmd_r9: assert property (@(posedge clk_i) disable iff (por_i)
    aux_en_o |-> aux_cmd_i);

  // R11: drive never on without PWM
  p_drv_pwm_r11: assert property (@(posedge clk_i) disable iff (por_i)
    drv_en_o |-> pwm_i);
endmodule

bind gdfp_fault_ctrl gdfp_chk #(.N_CMP(N_CMP)) chk_i (
  .clk_i     (clk_i),
  .por_i     (por_i),
  .pwm_i     (pwm_i),
  .ocp_i     (ocp_i),
  .cmp_i     (cmp_i),
  .aux_cmd_i (aux_cmd_i),
  .drv_en_o  (drv_en_o),
  .aux_en_o  (aux_en_o),
  .flt_n_o   (flt_n_o)
);

// File: tb/gdfp_fault_ctrl_tb_top.sv
`timescale 1ns/1ps
module gdfp_fault_ctrl_tb_top;
  localparam int unsigned WIN = 5;
  localparam int unsigned NC  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          por, pwm, clr_n, ocp_force, aux_cmd, aux_clr;
  logic [NC-1:0] cmp;
  logic          oc_loop, oc_present;
  logic          ocp;
  logic          drv, aux, flt_n;

  always_comb ocp = oc_loop ? (oc_present & drv) : ocp_force;

  gdfp_fault_ctrl #(.WIN_CYC(WIN), .N_CMP(NC)) dut_i (
    .clk_i(clk), .por_i(por), .pwm_i(pwm), .flt_clr_n_i(clr_n),
    .ocp_i(ocp), .cmp_i(cmp), .aux_cmd_i(aux_cmd), .aux_clr_i(aux_clr),
    .drv_en_o(drv), .aux_en_o(aux), .flt_n_o(flt_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic expect1(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // advance one clock; returns 2 ns after the edge
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle_inputs();
    pwm = 1'b0; clr_n = 1'b1; ocp_force = 1'b0; cmp = '0;
    aux_cmd = 1'b0; aux_clr = 1'b0; oc_loop = 1'b0; oc_present = 1'b0;
  endtask

  task automatic clean_all();
    idle_inputs(); por = 1'b1; step(); step(); por = 1'b0; step();
  endtask

  initial begin
    idle_inputs(); por = 1'b1;
    step();
    // R1: exhaustive sweep of inputs during reset
    for (int i = 0; i < 256; i++) begin
      {pwm, clr_n, ocp_force, cmp, aux_cmd, aux_clr, oc_present} = 8'(i);
      #1;
      expect1("R1 drv", drv, 1'b0);
      expect1("R1 aux", aux, 1'b0);
      expect1("R1 flt_n", flt_n, 1'b1);
      step();
    end
    idle_inputs(); por = 1'b0; step();

    // R11 / R9: pass-through sweep, nothing latched after reset (R1)
    for (int i = 0; i < 4; i++) begin
      {pwm, aux_cmd} = 2'(i);
      #1;
      expect1("R11 drv follows pwm", drv, pwm);
      expect1("R9 aux follows cmd", aux, aux_cmd);
      expect1("R1 no fault after reset", flt_n, 1'b1);
      step();
    end

    // R2 / R4 / R6 / R3 / R10: single overcurrent pulse
    pwm = 1'b1; aux_cmd = 1'b1; ocp_force = 1'b1; #1;
    step(); ocp_force = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      #1;
      expect1("R4 report low in window", flt_n, 1'b0);
      expect1("R6 drive off in window", drv, 1'b0);
      if (k > 0) expect1("R10 aux locked", aux, 1'b0);
      step();
    end
    #1;
    expect1("R4 window ends after WIN", flt_n, 1'b1);
    expect1("R3 latch holds, drive off", drv, 1'b0);
    expect1("R10 aux still locked", aux, 1'b0);
    // R2: set wins over an active clear; R5: no new window from held latch
    ocp_force = 1'b1; clr_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(); #1;
      expect1("R2 held ocp keeps drive off", drv, 1'b0);
      expect1("R5 no window from held latch", flt_n, 1'b1);
    end
    ocp_force = 1'b0; step(); #1;
    expect1("R3 clear via clr_n", drv, 1'b1);
    clr_n = 1'b1;
    // R10: aux clear after report high
    aux_clr = 1'b1; step(); aux_clr = 1'b0; #1;
    expect1("R10 aux released by clear", aux, 1'b1);

    // R3: clear via pwm low
    ocp_force = 1'b1; step(); ocp_force = 1'b0;
    repeat (WIN) step();
    #1; expect1("R3 hold before pwm low", drv, 1'b0);
    pwm = 1'b0; step(); pwm = 1'b1; #1;
    expect1("R3 drive back after pwm low", drv, 1'b1);

    // R5: re-set during the window does not extend it
    clean_all(); pwm = 1'b1;
    ocp_force = 1'b1; step();
    ocp_force = 1'b0; clr_n = 1'b0; step();       // latch cleared
    clr_n = 1'b1; ocp_force = 1'b1; step();       // set again inside window
    ocp_force = 1'b0;
    for (int k = 2; k < WIN; k++) begin
      #1; expect1("R5 still in window", flt_n, 1'b0); step();
    end
    #1;
    expect1("R5 window not extended", flt_n, 1'b1);
    expect1("R3 relatched, drive off", drv, 1'b0);

    // R7: continuous overcurrent retry
    clean_all();
    pwm = 1'b1; clr_n = 1'b0; oc_loop = 1'b1; oc_present = 1'b1; #1;
    begin
      int first;
      first = -1;
      for (int j = 0; j < 4 * (WIN + 1); j++) begin
        if (first < 0 && drv) first = j;
        if (first >= 0)
          expect1("R7 retry pattern", drv, ((j - first) % (WIN + 1)) == 0);
        step(); #1;
      end
      expect1("R7 retry started", first >= 0 && first <= 1, 1'b1);
    end
    oc_present = 1'b0; oc_loop = 1'b0;

    // R8: comparator latch, all flag combinations
    for (int i = 0; i < 4; i++) begin
      clean_all(); pwm = 1'b1;
      cmp = 2'(i); step(); cmp = '0;
      repeat (2) begin
        #1;
        expect1("R8 cmp latch sets report", flt_n, (i == 0));
        expect1("R6 drive off by report", drv, (i == 0));
        step();
      end
    end
    // R8: set wins over clear, then clear
    cmp = 2'b10; clr_n = 1'b0; step(); cmp = '0; #1;
    expect1("R8 set wins over clear", flt_n, 1'b0);
    step(); #1;
    expect1("R8 cleared by clr_n", flt_n, 1'b1);
    clr_n = 1'b1;

    // R10: aux clear ignored while report low; works afterwards
    clean_all(); aux_cmd = 1'b1;
    cmp = 2'b01; step(); cmp = '0;
    aux_clr = 1'b1; step(); step(); #1;
    expect1("R10 set wins during report", aux, 1'b0);
    aux_clr = 1'b0; clr_n = 1'b0; step(); clr_n = 1'b1; #1;
    expect1("R8 report released", flt_n, 1'b1);
    expect1("R10 aux held without clear", aux, 1'b0);
    step(); #1;
    expect1("R10 aux still held", aux, 1'b0);
    aux_clr = 1'b1; step(); aux_clr = 1'b0; #1;
    expect1("R10 aux restored", aux, 1'b1);

    // R1: reset mid-fault clears everything
    cmp = 2'b11; pwm = 1'b1; step(); cmp = '0;
    por = 1'b1; step(); por = 1'b0; #1;
    expect1("R1 fault cleared by reset", flt_n, 1'b1);
    expect1("R1 drive free after reset", drv, 1'b1);
    expect1("R1 aux latch cleared", aux, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule